// File: doc/BRIEF.md
# Nested Priority Interrupt Controller with Indirect Source Access

This block collects up to 128 interrupt inputs and raises a single interrupt request toward a processor. Every per-source setting (priority, trigger type, vector, enable, pending) is reached through one source-select register. Software writes a source number there, and the following indirect accesses act on that source alone. This keeps the register window small no matter how many sources a given instance implements.

Among the enabled, pending sources the block picks the one with the highest priority. On a tie, the lowest source number wins. Reading the vector register acknowledges the winner. The read returns the winner's vector and pushes the winner's priority onto an 8-entry nesting stack. While that entry sits on the stack, only a strictly higher priority can raise the request again. Each end-of-interrupt write pops one entry. When nothing wins, a vector read returns a programmable spurious value instead.

Top module: `nestIrqCtrl`

## Requirements
- R1: The select register (0x00) takes write data bits 6:0 as the source number. While that number is not below NUM_SRC, the mode, vector and command writes are ignored, and mode, vector and enable reads return 0.
- R2: The mode register (0x04) holds the priority in bits 2:0 and the trigger code in bits 6:5 (00 level-low, 01 level-high, 10 falling edge, 11 rising edge). The per-source vector register (0x08) holds 32 bits. Both read back for the selected source.
- R3: Writing 1 in bit 0 to 0x40 enables the selected source, and writing 1 in bit 0 to 0x44 disables it. Bit 0 of 0x30 reads the selected source's enable. A disabled source never raises the request.
- R4: Inputs are sampled on every clock. Edge-coded sources latch pending on their active edge. Level-coded sources are pending for as long as the sampled input is at its active level.
- R5: Writing 1 in bit 0 to 0x48 clears the selected source's pending latch. Writing 1 in bit 0 to 0x4C sets it.
- R6: irqReq is high exactly when some enabled pending source exists and either the stack is empty or that source's priority is greater than the priority on top of the stack.
- R7: Among candidates of equal top priority, the lowest source number wins.
- R8: A read of 0x10 while irqReq is high returns the winner's vector. In the same cycle it pushes the winner onto the stack and clears the winner's pending latch.
- R9: A read of 0x10 while irqReq is low returns the spurious value (0x3C, read/write) and changes no state.
- R10: The status register (0x18) reads 0 when the stack is empty. Otherwise bit 8 reads 1 and bits 6:0 hold the source number on top of the stack.
- R11: A write of any value to 0x38 pops one stack entry. The stack holds 8 entries, and a pop on an empty stack has no effect.
- R12: After reset all sources are disabled, not pending, with mode 0 and vector 0. The stack is empty, the spurious value is 0 and irqReq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqSrc | input | NUM_SRC | Interrupt inputs, synchronous to clk |
| busSel | input | 1 | Register access in this cycle |
| busWr | input | 1 | 1 for write, 0 for read |
| busAddr | input | 8 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid while busSel is high and busWr is low |
| irqReq | output | 1 | Interrupt request toward the processor |

## Verification
The hardest state to reach is a full stack of eight nested levels with a source still pending at the top priority. Only sources of strictly rising priority can be acknowledged on top of one another. The stimulus therefore sets up eight rising-edge sources with priorities 0 through 7 and pulses and acknowledges them in ascending order. It then forces the priority-7 source pending again, which must stay blocked until the first end-of-interrupt write uncovers priority 6. A behavioural model with queue-based stack bookkeeping is compared against irqReq on every clock and against every read.

// File: rtl/nicPkg.sv
package nicPkg;
  typedef struct packed {
    logic selWr;
    logic modeWr;
    logic vecWr;
    logic spuWr;
    logic enCmd;
    logic disCmd;
    logic clrCmd;
    logic setCmd;
    logic ack;
    logic eoi;
  } nicStrobes_t;

  typedef enum logic [1:0] {
    TRIG_LVL_LO = 2'b00,
    TRIG_LVL_HI = 2'b01,
    TRIG_FALL   = 2'b10,
    TRIG_RISE   = 2'b11
  } trig_t;

  localparam logic [7:0] ADDR_SEL  = 8'h00;
  localparam logic [7:0] ADDR_MODE = 8'h04;
  localparam logic [7:0] ADDR_VEC  = 8'h08;
  localparam logic [7:0] ADDR_IVEC = 8'h10;
  localparam logic [7:0] ADDR_STAT = 8'h18;
  localparam logic [7:0] ADDR_ENRD = 8'h30;
  localparam logic [7:0] ADDR_EOI  = 8'h38;
  localparam logic [7:0] ADDR_SPU  = 8'h3C;
  localparam logic [7:0] ADDR_EN   = 8'h40;
  localparam logic [7:0] ADDR_DIS  = 8'h44;
  localparam logic [7:0] ADDR_CLR  = 8'h48;
  localparam logic [7:0] ADDR_SET  = 8'h4C;
endpackage

// File: rtl/nicCtrl.sv
module nicCtrl
  import nicPkg::*;
(
  input  logic        busSel,
  input  logic        busWr,
  input  logic [7:0]  busAddr,
  input  logic        cmdBit,
  input  logic        irqReq,
  input  logic [31:0] modeRd,
  input  logic [31:0] vecRd,
  input  logic [31:0] ivecRd,
  input  logic [31:0] statRd,
  input  logic [31:0] enRd,
  input  logic [31:0] spuRd,
  output nicStrobes_t stb,
  output logic [31:0] busRdata
);
  logic wrOp, rdOp;
  assign wrOp = busSel & busWr;
  assign rdOp = busSel & ~busWr;

  always_comb begin
    stb        = '0;
    stb.selWr  = wrOp && busAddr == ADDR_SEL;
    stb.modeWr = wrOp && busAddr == ADDR_MODE;
    stb.vecWr  = wrOp && busAddr == ADDR_VEC;
    stb.spuWr  = wrOp && busAddr == ADDR_SPU;
    stb.enCmd  = wrOp && busAddr == ADDR_EN  && cmdBit;
    stb.disCmd = wrOp && busAddr == ADDR_DIS && cmdBit;
    stb.clrCmd = wrOp && busAddr == ADDR_CLR && cmdBit;
    stb.setCmd = wrOp && busAddr == ADDR_SET && cmdBit;
    stb.eoi    = wrOp && busAddr == ADDR_EOI;
    stb.ack    = rdOp && busAddr == ADDR_IVEC && irqReq;
  end

  always_comb begin
    busRdata = '0;
    if (rdOp) begin
      case (busAddr)
        ADDR_MODE: busRdata = modeRd;
        ADDR_VEC:  busRdata = vecRd;
        ADDR_IVEC: busRdata = ivecRd;
        ADDR_STAT: busRdata = statRd;
        ADDR_ENRD: busRdata = enRd;
        ADDR_SPU:  busRdata = spuRd;
        default:   busRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/nicDatapath.sv
module nicDatapath
  import nicPkg::*;
#(
  parameter int NUM_SRC   = 77,
  parameter int PRIO_W    = 3,
  parameter int VEC_W     = 32,
  parameter int STK_DEPTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqSrc,
  input  logic [31:0]        busWdata,
  input  nicStrobes_t        stb,
  output logic               irqReq,
  output logic [31:0]        modeRd,
  output logic [31:0]        vecRd,
  output logic [31:0]        ivecRd,
  output logic [31:0]        statRd,
  output logic [31:0]        enRd,
  output logic [31:0]        spuRd,
  output logic [$clog2(STK_DEPTH+1)-1:0] stkDepth
);
  localparam int SRC_W   = 7;
  localparam int IDX_W   = $clog2(STK_DEPTH);
  localparam int DEPTH_W = $clog2(STK_DEPTH + 1);

  logic [SRC_W-1:0]  selQ, selIdx;
  logic              selOk;
  logic [31:0]       spuQ;
  logic [NUM_SRC-1:0] req, srcEn;
  logic [PRIO_W-1:0] srcPrio [NUM_SRC];
  logic [1:0]        srcTrig [NUM_SRC];
  logic [VEC_W-1:0]  srcVec  [NUM_SRC];

  logic              winValid;
  logic [SRC_W-1:0]  winSrc;
  logic [PRIO_W-1:0] winPrio;

  logic [PRIO_W-1:0] stkPrio [STK_DEPTH];
  logic [SRC_W-1:0]  stkSrc  [STK_DEPTH];
  logic [DEPTH_W-1:0] depthQ;
  logic [IDX_W-1:0]  topIdx;
  logic              stkEmpty;

  assign selOk  = {1'b0, selQ} < (SRC_W + 1)'(NUM_SRC);
  assign selIdx = selOk ? selQ : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ <= '0;
      spuQ <= '0;
    end else begin
      if (stb.selWr) selQ <= busWdata[SRC_W-1:0];
      if (stb.spuWr) spuQ <= busWdata;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic              latchQ, inQ, enQ;
    logic [PRIO_W-1:0] prioQ;
    trig_t             trigQ;
    logic [VEC_W-1:0]  vecQ;
    logic              hitSel, edgeHit, lvlAct, setNow, clrNow;

    assign hitSel = selOk && (selQ == SRC_W'(i));

    always_comb begin
      case (trigQ)
        TRIG_RISE: edgeHit = irqSrc[i] & ~inQ;
        TRIG_FALL: edgeHit = ~irqSrc[i] & inQ;
        default:   edgeHit = 1'b0;
      endcase
    end

    assign lvlAct = (trigQ == TRIG_LVL_HI && inQ) || (trigQ == TRIG_LVL_LO && !inQ);
    assign setNow = edgeHit || (stb.setCmd && hitSel);
    assign clrNow = (stb.clrCmd && hitSel) || (stb.ack && winSrc == SRC_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        latchQ <= 1'b0;
        inQ    <= 1'b0;
        enQ    <= 1'b0;
        prioQ  <= '0;
        trigQ  <= TRIG_LVL_LO;
        vecQ   <= '0;
      end else begin
        inQ <= irqSrc[i];
        if (setNow)      latchQ <= 1'b1;
        else if (clrNow) latchQ <= 1'b0;
        if (stb.enCmd && hitSel)       enQ <= 1'b1;
        else if (stb.disCmd && hitSel) enQ <= 1'b0;
        if (stb.modeWr && hitSel) begin
          prioQ <= busWdata[PRIO_W-1:0];
          trigQ <= trig_t'(busWdata[6:5]);
        end
        if (stb.vecWr && hitSel) vecQ <= busWdata[VEC_W-1:0];
      end
    end

    assign req[i]     = enQ && (latchQ || lvlAct);
    assign srcEn[i]   = enQ;
    assign srcPrio[i] = prioQ;
    assign srcTrig[i] = trigQ;
    assign srcVec[i]  = vecQ;
  end

  // Highest priority wins; strict compare keeps the lowest index on ties.
  always_comb begin
    winValid = 1'b0;
    winSrc   = '0;
    winPrio  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req[i] && (!winValid || srcPrio[i] > winPrio)) begin
        winValid = 1'b1;
        winSrc   = SRC_W'(i);
        winPrio  = srcPrio[i];
      end
    end
  end

  assign stkEmpty = (depthQ == '0);
  assign topIdx   = IDX_W'(depthQ - 1'b1);
  assign irqReq   = winValid && (stkEmpty || winPrio > stkPrio[topIdx]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      depthQ <= '0;
      for (int k = 0; k < STK_DEPTH; k++) begin
        stkPrio[k] <= '0;
        stkSrc[k]  <= '0;
      end
    end else if (stb.ack && depthQ != DEPTH_W'(STK_DEPTH)) begin
      stkPrio[depthQ[IDX_W-1:0]] <= winPrio;
      stkSrc[depthQ[IDX_W-1:0]]  <= winSrc;
      depthQ <= depthQ + 1'b1;
    end else if (stb.eoi && !stkEmpty) begin
      depthQ <= depthQ - 1'b1;
    end
  end

  always_comb begin
    modeRd = '0;
    if (selOk) begin
      modeRd[6:5]        = srcTrig[selIdx];
      modeRd[PRIO_W-1:0] = srcPrio[selIdx];
    end
  end

  assign vecRd    = selOk ? 32'(srcVec[selIdx]) : '0;
  assign enRd     = {31'b0, selOk && srcEn[selIdx]};
  assign ivecRd   = irqReq ? 32'(srcVec[winSrc]) : spuQ;
  assign statRd   = stkEmpty ? '0 : {23'b0, 1'b1, 1'b0, stkSrc[topIdx]};
  assign spuRd    = spuQ;
  assign stkDepth = depthQ;
endmodule

// File: rtl/nestIrqCtrl.sv
module nestIrqCtrl
  import nicPkg::*;
#(
  parameter int NUM_SRC   = 77,
  parameter int PRIO_W    = 3,
  parameter int VEC_W     = 32,
  parameter int STK_DEPTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqSrc,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [7:0]         busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  output logic               irqReq
);
  localparam int DEPTH_W = $clog2(STK_DEPTH + 1);

  nicStrobes_t        stb;
  logic [31:0]        modeRd, vecRd, ivecRd, statRd, enRd, spuRd;
  logic [DEPTH_W-1:0] stkDepth;

  nicCtrl u_ctrl (
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .cmdBit(busWdata[0]),
    .irqReq(irqReq), .modeRd(modeRd), .vecRd(vecRd), .ivecRd(ivecRd),
    .statRd(statRd), .enRd(enRd), .spuRd(spuRd), .stb(stb), .busRdata(busRdata)
  );

  nicDatapath #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W), .STK_DEPTH(STK_DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .irqSrc(irqSrc), .busWdata(busWdata), .stb(stb),
    .irqReq(irqReq), .modeRd(modeRd), .vecRd(vecRd), .ivecRd(ivecRd),
    .statRd(statRd), .enRd(enRd), .spuRd(spuRd), .stkDepth(stkDepth)
  );
endmodule

// File: rtl/nestIrqCtrlChk.sv
module nestIrqCtrlChk #(
  parameter int STK_DEPTH = 8,
  parameter int DEPTH_W   = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               busSel,
  input logic               busWr,
  input logic [7:0]         busAddr,
  input logic               irqReq,
  input logic [DEPTH_W-1:0] stkDepth
);
  logic vecRead, eoiWrite;
  assign vecRead  = busSel && !busWr && busAddr == 8'h10;
  assign eoiWrite = busSel && busWr && busAddr == 8'h38;

  // R8: an acknowledging vector read adds one nesting level
  a_r8_ack_push: assert property (@(posedge clk) disable iff (!rstN)
    (vecRead && irqReq) |=> stkDepth == $past(stkDepth) + 1'b1);

  // R9: a vector read with no request leaves the stack untouched
  a_r9_spurious_no_push: assert property (@(posedge clk) disable iff (!rstN)
    (vecRead && !irqReq) |=> stkDepth == $past(stkDepth));

  // R11: end-of-interrupt pops exactly one level
  a_r11_eoi_pop: assert property (@(posedge clk) disable iff (!rstN)
    (eoiWrite && stkDepth != '0) |=> stkDepth == $past(stkDepth) - 1'b1);

  // R11: popping an empty stack keeps it empty
  a_r11_eoi_empty: assert property (@(posedge clk) disable iff (!rstN)
    (eoiWrite && stkDepth == '0) |=> stkDepth == '0);

  // R11: the stack never exceeds its depth
  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    stkDepth <= DEPTH_W'(STK_DEPTH));

  // R6: a full stack blocks every further request
  a_r6_full_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (stkDepth == DEPTH_W'(STK_DEPTH)) |-> !irqReq);
endmodule

bind nestIrqCtrl nestIrqCtrlChk #(.STK_DEPTH(STK_DEPTH), .DEPTH_W(DEPTH_W)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
  .irqReq(irqReq), .stkDepth(stkDepth)
);

// File: tb/nestIrqCtrl_tb.sv
module nestIrqCtrl_tb;
  localparam int NSRC = 77;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NSRC-1:0] irqSrc = '0;
  logic busSel = 1'b0, busWr = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic irqReq;

  int nChecks = 0;
  int nErr = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nestIrqCtrl #(.NUM_SRC(NSRC)) u_dut (
    .clk(clk), .rstN(rstN), .irqSrc(irqSrc), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqReq(irqReq)
  );

  // ---------------- behavioural reference model ----------------
  int mPrio [NSRC];
  int mTrig [NSRC];
  logic [31:0] mVec [NSRC];
  bit mEn [NSRC];
  bit mLatch [NSRC];
  bit mInQ [NSRC];
  int mSel;
  logic [31:0] mSpu;
  int stkSrcQ[$];
  int stkPriQ[$];

  function automatic bit mPend(int i);
    bit lvl;
    lvl = (mTrig[i] == 1 && mInQ[i]) || (mTrig[i] == 0 && !mInQ[i]);
    return mEn[i] && (mLatch[i] || lvl);
  endfunction

  function automatic int mWinner();
    int w = -1;
    for (int i = 0; i < NSRC; i++)
      if (mPend(i) && (w < 0 || mPrio[i] > mPrio[w])) w = i;
    return w;
  endfunction

  function automatic bit mIrq();
    int w = mWinner();
    if (w < 0) return 1'b0;
    if (stkPriQ.size() == 0) return 1'b1;
    return mPrio[w] > stkPriQ[stkPriQ.size()-1];
  endfunction

  function automatic logic [31:0] mRead(logic [7:0] a);
    bit ok = mSel < NSRC;
    case (a)
      8'h04: return ok ? 32'((mTrig[mSel] << 5) | mPrio[mSel]) : 32'h0;
      8'h08: return ok ? mVec[mSel] : 32'h0;
      8'h10: return mIrq() ? mVec[mWinner()] : mSpu;
      8'h18: return stkSrcQ.size() == 0 ? 32'h0 : 32'(32'h100 | stkSrcQ[stkSrcQ.size()-1]);
      8'h30: return (ok && mEn[mSel]) ? 32'h1 : 32'h0;
      8'h3C: return mSpu;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NSRC; i++) begin
        mPrio[i] = 0; mTrig[i] = 0; mVec[i] = '0; mEn[i] = 0; mLatch[i] = 0; mInQ[i] = 0;
      end
      mSel = 0; mSpu = '0;
      stkSrcQ.delete(); stkPriQ.delete();
    end else begin
      int w;
      bit irqNow, rdOp, wrOp, cmd;
      w = mWinner();
      irqNow = mIrq();
      rdOp = busSel && !busWr;
      wrOp = busSel && busWr;
      cmd = busWdata[0];
      for (int i = 0; i < NSRC; i++) begin
        bit edgeSeen, setIt, clrIt;
        edgeSeen = (mTrig[i] == 3 && irqSrc[i] && !mInQ[i]) ||
                   (mTrig[i] == 2 && !irqSrc[i] && mInQ[i]);
        setIt = edgeSeen || (wrOp && busAddr == 8'h4C && cmd && mSel == i);
        clrIt = (wrOp && busAddr == 8'h48 && cmd && mSel == i) ||
                (rdOp && busAddr == 8'h10 && irqNow && w == i);
        if (setIt) mLatch[i] = 1;
        else if (clrIt) mLatch[i] = 0;
        mInQ[i] = irqSrc[i];
      end
      if (rdOp && busAddr == 8'h10 && irqNow) begin
        stkSrcQ.push_back(w);
        stkPriQ.push_back(mPrio[w]);
      end
      if (wrOp) begin
        if (busAddr == 8'h00) mSel = int'(busWdata[6:0]);
        else if (busAddr == 8'h3C) mSpu = busWdata;
        else if (busAddr == 8'h38) begin
          if (stkSrcQ.size() > 0) begin
            void'(stkSrcQ.pop_back());
            void'(stkPriQ.pop_back());
          end
        end else if (mSel < NSRC) begin
          case (busAddr)
            8'h04: begin mPrio[mSel] = int'(busWdata[2:0]); mTrig[mSel] = int'(busWdata[6:5]); end
            8'h08: mVec[mSel] = busWdata;
            8'h40: if (cmd) mEn[mSel] = 1;
            8'h44: if (cmd) mEn[mSel] = 0;
            default: ;
          endcase
        end
      end
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R6: request compared with the model on every clock
  always @(negedge clk) begin
    if (rstN && !done) chk("R6 irqReq vs model", {31'b0, irqReq}, {31'b0, mIrq()});
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    #1 busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #2;
    chk({tag, " (model)"}, busRdata, mRead(a));
    chk(tag, busRdata, exp);
    @(posedge clk);
    #1 busSel = 1'b0;
  endtask

  task automatic setIn(int i, logic v);
    @(negedge clk);
    irqSrc[i] = v;
  endtask

  task automatic reqIs(logic e, string tag);
    @(negedge clk);
    #1 chk(tag, {31'b0, irqReq}, {31'b0, e});
  endtask

  task automatic cfg(int s, logic [31:0] mode, logic [31:0] vec);
    wr(8'h00, 32'(s));
    wr(8'h04, mode);
    wr(8'h08, vec);
    wr(8'h40, 32'h1);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    nErr++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;

    // R12 reset state
    reqIs(1'b0, "R12 irqReq after reset");
    rd(8'h18, 32'h0, "R12 status after reset");
    rd(8'h04, 32'h0, "R12 mode after reset");
    rd(8'h30, 32'h0, "R12 enable after reset");
    rd(8'h10, 32'h0, "R12 spurious after reset");

    // R9 spurious vector
    wr(8'h3C, 32'hDEAD_BEEF);
    rd(8'h10, 32'hDEAD_BEEF, "R9 spurious read");
    rd(8'h18, 32'h0, "R9 no push on spurious read");

    // R2 R3 R4 R8 R10: rising-edge source 5, priority 2
    cfg(5, 32'h62, 32'h500);
    rd(8'h04, 32'h62, "R2 mode readback");
    rd(8'h08, 32'h500, "R2 vector readback");
    rd(8'h30, 32'h1, "R3 enable readback");
    setIn(5, 1'b1);
    setIn(5, 1'b0);
    reqIs(1'b1, "R4 rising edge latched");
    rd(8'h18, 32'h0, "R10 status before ack");
    rd(8'h10, 32'h500, "R8 ack returns vector");
    reqIs(1'b0, "R8 ack clears edge pending");
    rd(8'h18, 32'h105, "R10 status after ack");

    // R6 R11: level-high source 9 preempts, then unwind
    cfg(9, 32'h25, 32'h900);
    setIn(9, 1'b1);
    reqIs(1'b1, "R6 higher priority preempts");
    rd(8'h10, 32'h900, "R8 nested ack vector");
    rd(8'h18, 32'h109, "R10 nested status");
    reqIs(1'b0, "R6 equal priority held off");
    setIn(9, 1'b0);
    wr(8'h38, 32'h0);
    rd(8'h18, 32'h105, "R11 one pop");
    wr(8'h38, 32'h0);
    rd(8'h18, 32'h0, "R11 back to idle");
    wr(8'h38, 32'h0);
    rd(8'h18, 32'h0, "R11 pop on empty ignored");

    // R7 tie, R5 set command
    cfg(20, 32'h63, 32'h2000);
    cfg(12, 32'h63, 32'h1200);
    wr(8'h00, 32'd20);
    wr(8'h4C, 32'h1);
    wr(8'h00, 32'd12);
    wr(8'h4C, 32'h1);
    rd(8'h10, 32'h1200, "R7 lowest index wins tie");
    rd(8'h18, 32'h10C, "R7 status of tie winner");
    reqIs(1'b0, "R6 same priority blocked");
    wr(8'h38, 32'h0);
    reqIs(1'b1, "R5 set-pending source requests");

    // R3 disable, R5 clear
    wr(8'h00, 32'd20);
    wr(8'h44, 32'h1);
    reqIs(1'b0, "R3 disabled source silent");
    rd(8'h30, 32'h0, "R3 enable cleared");
    wr(8'h40, 32'h0);
    rd(8'h30, 32'h0, "R3 command needs bit 0");
    wr(8'h40, 32'h1);
    reqIs(1'b1, "R3 re-enabled source requests");
    wr(8'h48, 32'h1);
    reqIs(1'b0, "R5 clear removes pending");
    wr(8'h44, 32'h1);

    // R11 eight nested levels
    for (int k = 0; k < 8; k++) cfg(30 + k, 32'h60 | 32'(k), 32'h3000 + 32'(k));
    for (int k = 0; k < 8; k++) begin
      setIn(30 + k, 1'b1);
      setIn(30 + k, 1'b0);
      reqIs(1'b1, "R11 next level requests");
      rd(8'h10, 32'h3000 + 32'(k), "R11 nested vector");
    end
    rd(8'h18, 32'h125, "R11 eight levels deep");
    wr(8'h4C, 32'h1);
    reqIs(1'b0, "R6 top priority blocked at full stack");
    wr(8'h38, 32'h0);
    reqIs(1'b1, "R6 priority 7 over exposed 6");
    for (int k = 0; k < 7; k++) wr(8'h38, 32'h0);
    rd(8'h18, 32'h0, "R11 eight pops reach idle");
    wr(8'h48, 32'h1);
    reqIs(1'b0, "R5 cleared after unwind");

    // R4 falling edge and level-low
    setIn(40, 1'b1);
    cfg(40, 32'h44, 32'h4000);
    reqIs(1'b0, "R4 falling source idle while high");
    setIn(40, 1'b0);
    reqIs(1'b1, "R4 falling edge latched");
    rd(8'h10, 32'h4000, "R4 falling vector");
    wr(8'h38, 32'h0);
    setIn(41, 1'b1);
    cfg(41, 32'h01, 32'h4100);
    reqIs(1'b0, "R4 level-low inactive when high");
    setIn(41, 1'b0);
    reqIs(1'b1, "R4 level-low active when low");
    rd(8'h10, 32'h4100, "R4 level-low vector");
    wr(8'h38, 32'h0);
    reqIs(1'b1, "R4 level stays pending after ack");
    setIn(41, 1'b1);
    reqIs(1'b0, "R4 level follows input");
    wr(8'h44, 32'h1);

    // R1 selection range and width
    wr(8'h00, 32'd100);
    wr(8'h04, 32'h67);
    wr(8'h40, 32'h1);
    rd(8'h04, 32'h0, "R1 out-of-range mode read");
    rd(8'h30, 32'h0, "R1 out-of-range enable read");
    wr(8'h00, 32'h85);
    rd(8'h04, 32'h62, "R1 select uses low 7 bits");

    repeat (3) @(posedge clk);
    finishRun();
  end
endmodule